// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port sequencer that sits between a four-wire scan interface and a chip's test data registers. A sixteen-state machine advances on each rising edge of the test clock, steered by the mode-select input. It decodes its state into capture, shift and update strobes for the data-register path and the instruction path. Those strobes tell the attached data registers when to load parallel data, when to move one stage toward the serial output, and when to latch their result.

The controller owns a small instruction register, built as two parts. A shift stage sits in the serial path during instruction scans. A hold stage drives the current instruction to the rest of the chip. The hold stage changes only on the falling test-clock edge while the controller is in the instruction update state, or when the controller is in its reset state, where it takes the identification opcode.

The serial output is retimed on the falling clock edge. It is driven only while a shift state is active; at all other times its enable is low so the line can float. A synchronous active-high reset forces the reset state.

Top module: `jtag_tap`

## Requirements
- R1: With `rst` high at a rising `tck` edge the state becomes reset (code 4'hF). At the next falling edge `instr` becomes the identification opcode `IR_IDCODE` (3'b001) and `tdo_oe` goes low.
- R2: The state advances only on rising `tck`, using the `tms` value sampled there. `tap_state` carries these codes: reset F, idle C, DR-select 7, DR-capture 6, DR-shift 2, DR-exit1 1, DR-pause 3, DR-exit2 0, DR-update 5, IR-select 4, IR-capture E, IR-shift A, IR-exit1 9, IR-pause B, IR-exit2 8, IR-update D. The transitions below are written as "tms low / tms high":
  - reset: idle / reset
  - idle: idle / DR-select
  - DR-select: DR-capture / IR-select
  - IR-select: IR-capture / reset
  - capture: shift / exit1
  - shift: shift / exit1
  - exit1: pause / update
  - pause: pause / exit2
  - exit2: shift / update
  - either update state: idle / DR-select
- R3: From any state, five consecutive rising edges with `tms` high reach the reset state, and further edges with `tms` high keep it there.
- R4: Each of `capture_dr`, `shift_dr`, `update_dr`, `capture_ir`, `shift_ir`, `update_ir` and `logic_reset` is high exactly while the controller is in its matching state. At most one of them is high at a time.
- R5: A rising edge in IR-capture loads the shift stage with 3'b100; bit 0 is the bit nearest `tdo`. The first three bits seen on `tdo` in IR-shift are therefore 0, 0, 1.
- R6: Each rising edge in IR-shift moves the shift stage one place toward bit 0 and loads `tdi` into the top bit.
- R7: `instr` takes the shift stage value on a falling edge in IR-update. It takes `IR_IDCODE` on a falling edge in the reset state. In every other state it keeps its value.
- R8: On each falling edge `tdo_oe` becomes high only if the state is IR-shift or DR-shift. In IR-shift, `tdo` takes bit 0 of the shift stage. In DR-shift, `tdo` takes `dr_so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| dr_so | input | 1 | Serial output of the selected data register |
| tdo | output | 1 | Serial data out, retimed on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| instr | output | IR_W | Current instruction (hold stage) |
| tap_state | output | 4 | Encoded controller state |
| capture_dr | output | 1 | DR-capture strobe |
| shift_dr | output | 1 | DR-shift strobe |
| update_dr | output | 1 | DR-update strobe |
| capture_ir | output | 1 | IR-capture strobe |
| shift_ir | output | 1 | IR-shift strobe |
| update_ir | output | 1 | IR-update strobe |
| logic_reset | output | 1 | High in the reset state |

## Verification
The bench builds the block with its defaults: a 3-bit instruction, capture pattern 3'b100 and identification opcode 3'b001. With a 3-bit width, every opcode can be shifted in within a few edges, and the full capture-then-shift sequence fits in a short scan. The bench walks directed paths through both pause loops. It then runs a long random `tms`/`tdi`/`dr_so` stream with occasional resets, which reaches all sixteen states and every transition.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        ST_DR_EX2   = 4'h0,
        ST_DR_EX1   = 4'h1,
        ST_DR_SHIFT = 4'h2,
        ST_DR_PAUSE = 4'h3,
        ST_IR_SEL   = 4'h4,
        ST_DR_UPD   = 4'h5,
        ST_DR_CAP   = 4'h6,
        ST_DR_SEL   = 4'h7,
        ST_IR_EX2   = 4'h8,
        ST_IR_EX1   = 4'h9,
        ST_IR_SHIFT = 4'hA,
        ST_IR_PAUSE = 4'hB,
        ST_IDLE     = 4'hC,
        ST_IR_UPD   = 4'hD,
        ST_IR_CAP   = 4'hE,
        ST_RESET    = 4'hF
    } tap_state_e;

    typedef struct packed {
        logic cap_dr;
        logic sft_dr;
        logic upd_dr;
        logic cap_ir;
        logic sft_ir;
        logic upd_ir;
        logic in_reset;
    } tap_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   n = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   n = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_SHIFT: n = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_EX1:   n = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: n = tms ? ST_DR_EX2   : ST_DR_PAUSE;
            ST_DR_EX2:   n = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   n = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   n = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_SHIFT: n = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_EX1:   n = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: n = tms ? ST_IR_EX2   : ST_IR_PAUSE;
            ST_IR_EX2:   n = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   n = tms ? ST_DR_SEL   : ST_IDLE;
            default:     n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic tap_ctl_t tap_decode(input tap_state_e s);
        tap_ctl_t c;
        c.cap_dr   = (s == ST_DR_CAP);
        c.sft_dr   = (s == ST_DR_SHIFT);
        c.upd_dr   = (s == ST_DR_UPD);
        c.cap_ir   = (s == ST_IR_CAP);
        c.sft_ir   = (s == ST_IR_SHIFT);
        c.upd_ir   = (s == ST_IR_UPD);
        c.in_reset = (s == ST_RESET);
        return c;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    assign ctl = tap_decode(state);

    // R3
    reset_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (ctl.in_reset && tms) |=> ctl.in_reset);

    // R2
    dr_shift_stay_chk: assert property (@(posedge tck) disable iff (rst)
        (ctl.sft_dr && !tms) |=> ctl.sft_dr);

    // R4
    strobe_onehot_chk: assert property (@(posedge tck) disable iff (rst)
        $onehot0(ctl));

endmodule

// File: rtl/tap_ir.sv
module tap_ir #(
    parameter int unsigned         IR_W       = 3,
    parameter logic [IR_W-1:0]     IR_CAPTURE = 3'b100,
    parameter logic [IR_W-1:0]     IR_IDCODE  = 3'b001
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  logic            cap,
    input  logic            sft,
    input  logic            upd,
    input  logic            in_reset,
    output logic            ir_lsb,
    output logic [IR_W-1:0] instr
);

    logic [IR_W-1:0] ir_sr;

    generate
        if (IR_W > 1) begin : g_wide
            always_ff @(posedge tck) begin
                if (rst)      ir_sr <= '0;
                else if (cap) ir_sr <= IR_CAPTURE;
                else if (sft) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            end
        end else begin : g_single
            always_ff @(posedge tck) begin
                if (rst)      ir_sr <= '0;
                else if (cap) ir_sr <= IR_CAPTURE;
                else if (sft) ir_sr <= tdi;
            end
        end
    endgenerate

    always_ff @(negedge tck) begin
        if (rst || in_reset) instr <= IR_IDCODE;
        else if (upd)        instr <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    // R5
    capture_load_chk: assert property (@(posedge tck) disable iff (rst)
        cap |=> (ir_sr == IR_CAPTURE));

    // R7
    instr_hold_chk: assert property (@(negedge tck) disable iff (rst)
        $past(rst) || $past(upd) || $past(in_reset) || $stable(instr));

endmodule

// File: rtl/tap_tdo.sv
module tap_tdo (
    input  logic tck,
    input  logic rst,
    input  logic sft_ir,
    input  logic sft_dr,
    input  logic ir_lsb,
    input  logic dr_so,
    output logic tdo,
    output logic tdo_oe
);

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= sft_ir | sft_dr;
            if (sft_ir)      tdo <= ir_lsb;
            else if (sft_dr) tdo <= dr_so;
        end
    end

    // R8
    oe_window_chk: assert property (@(negedge tck) disable iff (rst)
        $past(rst) || (tdo_oe == ($past(sft_ir) || $past(sft_dr))));

    // R8
    ir_out_chk: assert property (@(negedge tck) disable iff (rst)
        (!$past(rst) && $past(sft_ir)) |-> (tdo == $past(ir_lsb)));

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
    import tap_pkg::*;
#(
    parameter int unsigned     IR_W       = 3,
    parameter logic [IR_W-1:0] IR_CAPTURE = 3'b100,
    parameter logic [IR_W-1:0] IR_IDCODE  = 3'b001
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tms,
    input  logic            tdi,
    input  logic            dr_so,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [IR_W-1:0] instr,
    output logic [3:0]      tap_state,
    output logic            capture_dr,
    output logic            shift_dr,
    output logic            update_dr,
    output logic            capture_ir,
    output logic            shift_ir,
    output logic            update_ir,
    output logic            logic_reset
);

    tap_state_e state;
    tap_ctl_t   ctl;
    logic       ir_lsb;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state),
        .ctl   (ctl)
    );

    tap_ir #(
        .IR_W       (IR_W),
        .IR_CAPTURE (IR_CAPTURE),
        .IR_IDCODE  (IR_IDCODE)
    ) u_ir (
        .tck      (tck),
        .rst      (rst),
        .tdi      (tdi),
        .cap      (ctl.cap_ir),
        .sft      (ctl.sft_ir),
        .upd      (ctl.upd_ir),
        .in_reset (ctl.in_reset),
        .ir_lsb   (ir_lsb),
        .instr    (instr)
    );

    tap_tdo u_tdo (
        .tck    (tck),
        .rst    (rst),
        .sft_ir (ctl.sft_ir),
        .sft_dr (ctl.sft_dr),
        .ir_lsb (ir_lsb),
        .dr_so  (dr_so),
        .tdo    (tdo),
        .tdo_oe (tdo_oe)
    );

    assign tap_state   = state;
    assign capture_dr  = ctl.cap_dr;
    assign shift_dr    = ctl.sft_dr;
    assign update_dr   = ctl.upd_dr;
    assign capture_ir  = ctl.cap_ir;
    assign shift_ir    = ctl.sft_ir;
    assign update_ir   = ctl.upd_ir;
    assign logic_reset = ctl.in_reset;

endmodule

// File: tb/jtag_tap_bench.sv
module jtag_tap_bench;

    localparam logic [2:0] IDC = 3'b001;
    localparam logic [3:0] S_RST = 4'hF, S_IDL = 4'hC, S_DSL = 4'h7, S_DCP = 4'h6,
                           S_DSH = 4'h2, S_DX1 = 4'h1, S_DPA = 4'h3, S_DX2 = 4'h0,
                           S_DUP = 4'h5, S_ISL = 4'h4, S_ICP = 4'hE, S_ISH = 4'hA,
                           S_IX1 = 4'h9, S_IPA = 4'hB, S_IX2 = 4'h8, S_IUP = 4'hD;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic dr_so = 1'b0;
    logic tdo, tdo_oe;
    logic [2:0] instr;
    logic [3:0] tap_state;
    logic capture_dr, shift_dr, update_dr, capture_ir, shift_ir, update_ir, logic_reset;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [3:0] m_state = S_RST;
    logic [2:0] m_ir = '0;
    logic [2:0] m_instr = IDC;
    logic       m_tdo = 1'b0;
    logic       m_oe = 1'b0;

    always #10 tck = ~tck;

    jtag_tap u_jtag_tap (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .dr_so(dr_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .instr(instr), .tap_state(tap_state),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .logic_reset(logic_reset)
    );

    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic t);
        case (s)
            S_RST: return t ? S_RST : S_IDL;
            S_IDL: return t ? S_DSL : S_IDL;
            S_DSL: return t ? S_ISL : S_DCP;
            S_ISL: return t ? S_RST : S_ICP;
            S_DCP, S_DSH: return t ? S_DX1 : S_DSH;
            S_ICP, S_ISH: return t ? S_IX1 : S_ISH;
            S_DX1: return t ? S_DUP : S_DPA;
            S_IX1: return t ? S_IUP : S_IPA;
            S_DPA: return t ? S_DX2 : S_DPA;
            S_IPA: return t ? S_IX2 : S_IPA;
            S_DX2: return t ? S_DUP : S_DSH;
            S_IX2: return t ? S_IUP : S_ISH;
            default: return t ? S_DSL : S_IDL;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 state", tap_state, m_state);
        check("R4 strobes",
              {capture_dr, shift_dr, update_dr, capture_ir, shift_ir, update_ir, logic_reset},
              {m_state == S_DCP, m_state == S_DSH, m_state == S_DUP, m_state == S_ICP,
               m_state == S_ISH, m_state == S_IUP, m_state == S_RST});
        check("R7 instr", instr, m_instr);
        check("R8 tdo_oe", tdo_oe, m_oe);
        if (m_oe) check("R8 tdo", tdo, m_tdo);
    endtask

    // one tck period: inputs change just after a falling edge
    task automatic cyc(input logic t, input logic d, input logic so);
        tms = t; tdi = d; dr_so = so;
        @(posedge tck);
        if (rst) begin
            m_state = S_RST;
            m_ir = '0;
        end else begin
            if (m_state == S_ICP) m_ir = 3'b100;
            else if (m_state == S_ISH) m_ir = {d, m_ir[2:1]};
            m_state = ref_next(m_state, t);
        end
        @(negedge tck);
        if (rst) begin
            m_instr = IDC; m_oe = 0; m_tdo = 0;
        end else begin
            if (m_state == S_RST) m_instr = IDC;
            else if (m_state == S_IUP) m_instr = m_ir;
            if (m_state == S_ISH) begin m_tdo = m_ir[0]; m_oe = 1; end
            else if (m_state == S_DSH) begin m_tdo = so; m_oe = 1; end
            else m_oe = 0;
        end
        #1;
        compare_all();
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        if (!done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        // R1 reset state
        check("R1 state", tap_state, S_RST);
        check("R1 instr", instr, IDC);
        check("R1 tdo_oe", tdo_oe, 0);
        check("R1 logic_reset", logic_reset, 1);
        rst = 0;

        // IR scan: capture then shift 1,0,1
        cyc(0, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        check("R5 shift_ir entered", shift_ir, 1);
        check("R5 tdo bit0", tdo, 0);
        cyc(0, 1, 0);
        check("R5 tdo bit1", tdo, 0);
        cyc(0, 0, 0);
        check("R5 tdo bit2", tdo, 1);
        cyc(1, 1, 0);
        check("R2 exit1-ir", tap_state, S_IX1);
        cyc(1, 0, 0);
        check("R7 update loads 101", instr, 3'b101);

        // second IR scan via pause, reading back shifted bits
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 1, 0);
        check("R6 first fed bit out", tdo, 0);
        cyc(0, 1, 0);
        check("R6 second fed bit out", tdo, 1);
        cyc(1, 0, 0);
        check("R7 held outside update", instr, 3'b101);
        cyc(0, 0, 0); cyc(0, 0, 0);
        check("R2 ir pause hold", tap_state, S_IPA);
        cyc(1, 0, 0); cyc(1, 0, 0);
        check("R7 update loads 011", instr, 3'b011);

        // DR scan with dr_so pattern
        cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 1);
        check("R8 dr tdo a", tdo, 1);
        cyc(0, 0, 0);
        check("R8 dr tdo b", tdo, 0);
        cyc(0, 0, 1);
        check("R8 dr tdo c", tdo, 1);
        check("R8 dr oe", tdo_oe, 1);
        cyc(1, 0, 0); cyc(0, 0, 0);
        check("R2 dr pause", tap_state, S_DPA);
        check("R8 oe low in pause", tdo_oe, 0);
        check("R7 instr kept through DR", instr, 3'b011);

        // R3: five tms-high edges from DR-pause
        for (int i = 0; i < 5; i++) cyc(1, 0, 0);
        check("R3 reached reset", tap_state, S_RST);
        check("R3 instr back to idcode", instr, IDC);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);
        check("R3 stays in reset", tap_state, S_RST);

        // random stream, occasional reset
        for (int i = 0; i < 3000; i++) begin
            rst = (($urandom % 97) == 0);
            cyc(logic'(($urandom % 3) == 0), logic'($urandom % 2), logic'($urandom % 2));
        end
        rst = 0;
        for (int i = 0; i < 5; i++) cyc(1, 0, 0);
        check("R3 reset after random run", tap_state, S_RST);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule